// File: doc/BRIEF.md
# Directional Edge Check Unit

This unit is the second stage of a switching impulse-noise detector that works on a 3x3 pixel neighbourhood. An earlier smoothness stage marks the centre pixel as suspicious when it stands apart from its surroundings. That mark alone cannot tell a corrupted pixel from a clean pixel that sits on an object boundary. This unit settles that question. It looks along four lines through the centre: horizontal, vertical, main diagonal and anti-diagonal. A line whose two outer pixels both stay close to the centre value shows an edge.

For each line the unit forms two absolute differences against the centre and compares each with a programmable threshold. If neither difference is larger than the threshold, that line reports an edge. The per-line edge flags together drive the select input of a 2:1 multiplexer. When any line reports an edge, the multiplexer clears the pixel. When no line does, it passes the suspicion from the earlier stage through. A non-suspicious pixel is never flagged. The datapath is combinational, and by default a single output register follows it.

The window arrives as one flat vector, with pixel k (row-major, k = 3*row + col) in bits [k*PIX_W +: PIX_W]. The centre is pixel 4.

Top module: `edge_check_unit`

## Requirements
- R1: The four lines use these pixel pairs around the centre (index 4): line 0 (bit 0 of `edge_dir_o`) pixels 3 and 5; line 1 (bit 1) pixels 1 and 7; line 2 (bit 2) pixels 0 and 8; line 3 (bit 3) pixels 2 and 6.
- R2: A line's edge bit is 1 exactly when both |centre - pixel| values on that line are less than or equal to `thr_i`. A difference equal to the threshold still counts as close.
- R3: `noisy_o` is 1 only when `suspect_i` was 1 and no bit of `edge_dir_o` is set. Any reported edge clears the pixel.
- R4: When `suspect_i` is 0, `noisy_o` is 0 whatever the window and threshold are.
- R5: `edge_dir_o` reports the per-line results whatever the value of `suspect_i` is.
- R6: With `REG_OUT` = 1, both outputs follow the inputs one clock later and stay unchanged between rising edges. While `rst_n` is low, both outputs are 0.
- R7: The difference is an absolute value: a neighbour above the centre by d behaves the same as one below it by d.
- R8: With `thr_i` = 0, a line reports an edge only when both of its pixels equal the centre.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_i | input | 9*PIX_W | 3x3 window, row-major, pixel k at bits [k*PIX_W +: PIX_W] |
| thr_i | input | PIX_W | Closeness threshold |
| suspect_i | input | 1 | Suspicion flag from the smoothness stage |
| noisy_o | output | 1 | Final decision: 1 means the centre pixel is treated as noise |
| edge_dir_o | output | 4 | Per-line edge flags, bit order as in R1 |

## Verification
The timed properties assume the default registered build and assume that `suspect_i`, `win_i` and `thr_i` are driven to known values at every clock edge after reset. The bench therefore changes inputs only on the falling edge and keeps them steady across each rising edge. The band check on each line treats pixels and threshold as unsigned values of the configured width. The stimulus sweeps offsets around the threshold on every line while the other pixels sit far from the centre, so no line outside the one under test can report an edge. A long pseudo-random run then mixes both suspicion levels with threshold values that leave some lines near the band edge.

// File: rtl/edge_chk_pkg.sv
package edge_chk_pkg;

    localparam int NUM_DIR = 4;
    localparam int NUM_PIX = 9;
    localparam int CTR_IDX = 4;

    // Distance in row-major index from the centre to each end of a line
    function automatic int dir_step(input int dir);
        case (dir)
            0:       return 1;   // horizontal
            1:       return 3;   // vertical
            2:       return 4;   // main diagonal
            default: return 2;   // anti-diagonal
        endcase
    endfunction

    function automatic int nbr_lo(input int dir);
        return CTR_IDX - dir_step(dir);
    endfunction

    function automatic int nbr_hi(input int dir);
        return CTR_IDX + dir_step(dir);
    endfunction

    typedef struct packed {
        logic               noisy;
        logic [NUM_DIR-1:0] edge_dir;
    } decision_t;

endpackage

// File: rtl/ec_absdiff.sv
module ec_absdiff #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] d_o
);
    always_comb begin
        if (a_i >= b_i) d_o = a_i - b_i;
        else            d_o = b_i - a_i;
    end
endmodule

// File: rtl/ec_dir_test.sv
module ec_dir_test #(
    parameter int W = 8
) (
    input  logic [W-1:0] ctr_i,
    input  logic [W-1:0] nb_lo_i,
    input  logic [W-1:0] nb_hi_i,
    input  logic [W-1:0] thr_i,
    output logic         is_edge_o
);
    logic [W-1:0] dist_lo;
    logic [W-1:0] dist_hi;
    logic         far_lo;
    logic         far_hi;

    ec_absdiff #(.W(W)) u_dlo (.a_i(ctr_i), .b_i(nb_lo_i), .d_o(dist_lo));
    ec_absdiff #(.W(W)) u_dhi (.a_i(ctr_i), .b_i(nb_hi_i), .d_o(dist_hi));

    always_comb begin
        far_lo    = dist_lo > thr_i;
        far_hi    = dist_hi > thr_i;
        is_edge_o = ~(far_lo | far_hi);
    end

    // An edge line keeps both ends inside the band [centre-thr, centre+thr]
    always_comb begin
        if (is_edge_o) begin
            AST_EDGE_IN_BAND: assert ((int'(nb_lo_i) + int'(thr_i) >= int'(ctr_i))
                                   && (int'(nb_lo_i) <= int'(ctr_i) + int'(thr_i))
                                   && (int'(nb_hi_i) + int'(thr_i) >= int'(ctr_i))
                                   && (int'(nb_hi_i) <= int'(ctr_i) + int'(thr_i)))
                else $error("edge flag outside band"); // R2
        end
    end
endmodule

// File: rtl/ec_decide.sv
module ec_decide #(
    parameter int N = 4
) (
    input  logic [N-1:0] edge_i,
    input  logic         suspect_i,
    output logic         noisy_o
);
    logic sel;

    always_comb begin
        sel = |edge_i;
        // 2:1 select: an edge on any line overrides the suspicion
        noisy_o = sel ? 1'b0 : suspect_i;
    end

    always_comb begin
        if (noisy_o) begin
            AST_NOISY_NEEDS_SUSPECT: assert (suspect_i)
                else $error("noise flag without suspicion"); // R4
        end
    end
endmodule

// File: rtl/edge_check_unit.sv
module edge_check_unit
    import edge_chk_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PIX*PIX_W-1:0]   win_i,
    input  logic [PIX_W-1:0]           thr_i,
    input  logic                       suspect_i,
    output logic                       noisy_o,
    output logic [NUM_DIR-1:0]         edge_dir_o
);
    logic [PIX_W-1:0]   ctr;
    logic [NUM_DIR-1:0] dir_edge;
    logic               noisy_c;
    decision_t          dec_d;
    decision_t          dec_q;

    assign ctr = win_i[CTR_IDX*PIX_W +: PIX_W];

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        localparam int LO = nbr_lo(g);
        localparam int HI = nbr_hi(g);
        ec_dir_test #(.W(PIX_W)) u_dir (
            .ctr_i    (ctr),
            .nb_lo_i  (win_i[LO*PIX_W +: PIX_W]),
            .nb_hi_i  (win_i[HI*PIX_W +: PIX_W]),
            .thr_i    (thr_i),
            .is_edge_o(dir_edge[g])
        );
    end

    ec_decide #(.N(NUM_DIR)) u_decide (
        .edge_i   (dir_edge),
        .suspect_i(suspect_i),
        .noisy_o  (noisy_c)
    );

    always_comb begin
        dec_d          = '0;
        dec_d.noisy    = noisy_c;
        dec_d.edge_dir = dir_edge;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dec_q <= '0;
            else        dec_q <= dec_d;
        end

        AST_BYPASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !suspect_i |=> !noisy_o) else $error("bypass failed"); // R4
        AST_EDGE_BLOCKS_NOISE: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_dir_o != '0) |-> !noisy_o) else $error("edge not honoured"); // R3
        AST_NOISE_FROM_SUSPECT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(noisy_o) |-> $past(suspect_i)) else $error("noise without cause"); // R6
    end else begin : g_comb
        assign dec_q = dec_d;
    end

    assign noisy_o    = dec_q.noisy;
    assign edge_dir_o = dec_q.edge_dir;
endmodule

// File: tb/tb_edge_check_unit.sv
`timescale 1ns/1ps
module tb_edge_check_unit;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [9*W-1:0] win = '0;
    logic [W-1:0] thr = '0;
    logic         susp = 1'b0;
    logic         noisy;
    logic [3:0]   edir;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    edge_check_unit #(.PIX_W(W), .REG_OUT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .win_i(win), .thr_i(thr),
        .suspect_i(susp), .noisy_o(noisy), .edge_dir_o(edir)
    );

    // Line pairs as stated in R1
    int pa [4] = '{3, 1, 0, 2};
    int pb [4] = '{5, 7, 8, 6};

    function automatic int pix(input logic [9*W-1:0] w, input int k);
        return int'(w[k*W +: W]);
    endfunction

    function automatic logic [3:0] model_edges(input logic [9*W-1:0] w, input int t);
        logic [3:0] r;
        int c;
        int da;
        int db;
        c = pix(w, 4);
        for (int d = 0; d < 4; d++) begin
            da = c - pix(w, pa[d]);
            db = c - pix(w, pb[d]);
            if (da < 0) da = -da;
            if (db < 0) db = -db;
            r[d] = (da <= t) && (db <= t);
        end
        return r;
    endfunction

    task automatic check(input logic [3:0] exp_e, input logic exp_n, input string req);
        n_chk++;
        if (edir !== exp_e || noisy !== exp_n) begin
            n_fail++;
            $display("FAIL %s: got edge=%b noisy=%b expected edge=%b noisy=%b",
                     req, edir, noisy, exp_e, exp_n);
        end
    endtask

    // Drive on falling edge, result appears after the next rising edge
    task automatic apply_and_check(input logic [9*W-1:0] w, input int t, input logic s,
                                   input string req);
        logic [3:0] e;
        @(negedge clk);
        win = w; thr = W'(t); susp = s;
        e = model_edges(w, t);
        @(negedge clk);
        check(e, s && (e == 4'b0), req);
    endtask

    function automatic logic [9*W-1:0] far_window(input int c);
        logic [9*W-1:0] w;
        for (int k = 0; k < 9; k++) w[k*W +: W] = W'(c + 150);
        w[4*W +: W] = W'(c);
        return w;
    endfunction

    initial begin
        #(8ns * 190000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int tl [4] = '{0, 1, 7, 30};
        int offs [5];
        logic [9*W-1:0] w;
        logic [15:0] lfsr;
        string tag;

        // Reset state (R6)
        win = far_window(100); susp = 1'b1; thr = 8'd200;
        repeat (3) @(negedge clk);
        check(4'b0, 1'b0, "R6 reset");
        rst_n = 1'b1;

        // Directed sweep around the band edge on every line
        foreach (tl[ti]) begin
            int t = tl[ti];
            offs = '{-t-1, -t, 0, t, t+1};
            for (int d = 0; d < 4; d++) begin
                for (int i = 0; i < 5; i++) begin
                    for (int j = 0; j < 5; j++) begin
                        w = far_window(100);
                        w[pa[d]*W +: W] = W'(100 + offs[i]);
                        w[pb[d]*W +: W] = W'(100 + offs[j]);
                        if (t == 0)                         tag = "R8 R1";
                        else if (offs[i] < 0 || offs[j] < 0) tag = "R7 R2 R1";
                        else                                tag = "R2 R3 R1";
                        apply_and_check(w, t, 1'b1, tag);
                    end
                end
            end
        end

        // Latency and hold between edges (R6)
        @(negedge clk);
        win = far_window(60); thr = 8'd5; susp = 1'b1;
        @(negedge clk);
        check(4'b0000, 1'b1, "R6 settle");
        @(negedge clk);
        win[3*W +: W] = 8'd60; win[5*W +: W] = 8'd62;
        #1;
        check(4'b0000, 1'b1, "R6 hold before edge");
        @(negedge clk);
        check(4'b0001, 1'b0, "R6 after edge R3");

        // Pseudo-random windows, both suspicion levels (R3 R4 R5)
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            int c;
            int t;
            c = 20 + (n % 200);
            for (int k = 0; k < 9; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                w[k*W +: W] = W'(c + int'(lfsr[4:0]) - 16);
            end
            w[4*W +: W] = W'(c);
            t = int'(lfsr[8:5]);
            apply_and_check(w, t, lfsr[9], lfsr[9] ? "R3 R5" : "R4 R5");
        end

        // Large threshold clears everything; bypass with all lines edge (R4)
        apply_and_check(far_window(10), 255, 1'b0, "R4 R5");
        apply_and_check(far_window(10), 255, 1'b1, "R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule